// File: doc/BRIEF.md
# Triplicated Control Bit Guard

This block keeps a handful of safety-relevant control bits (per-channel run enables and protection switches) as three separate register copies and presents each bit as the two-of-three majority of those copies. A copy that disagrees with the others is outvoted, so one upset never reaches the output. The disagreement is still reported on a redundancy error flag. Alongside the control bits, the block holds a small bank of ordinary configuration registers. Each of these has its own even-parity bit, which is compared against the data on every cycle. A mismatch raises a sequencer error flag.

Software reaches everything through a single-cycle register port. A write takes effect at the clock edge. A read returns data combinationally in the cycle it is requested, and any clear-on-read side effect lands at that same edge. A fault-injection register lets test software invert one or two copies of any control bit. It can also invert the stored parity bit of a chosen configuration register, but only when every channel enable is off. This proves that both detectors work. The removal of an injected fault follows a fixed sequence: clear the injection, then read status.

Top module: `safety_cfg_guard`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, and after it is released, the voted bits, both error flags and every readback are zero.
- R2: A write to address 0 loads all three copies of the control bits from `wrData[PROT_BITS-1:0]`. From the next cycle, `votedBits` and reads of address 0 return that value.
- R3: Address 1 is the fault-injection register. Setting bit k of its field [PROT_BITS-1:0] inverts copy A of control bit k. This leaves `votedBits` unchanged, and `redErr` reads 1 from the cycle after the write.
- R4: Setting bit k in both field [PROT_BITS-1:0] and field [2*PROT_BITS-1:PROT_BITS] (copy B) makes the vote follow the wrong majority, so voted bit k inverts, and `redErr` is 1.
- R5: Once the injection bits are written back to zero, `redErr` stays 1 until a read of status address 2. That read still returns 1 in bit 0, and the flag is 0 afterwards. A status read taken while copies still disagree leaves the flag at 1.
- R6: A write to address 0 also zeroes both injection fields and clears `redErr` from the next cycle.
- R7: Configuration register i is at address 4+i. It reads back what was written, and a normal write leaves `seqErr` at 0, because parity is recomputed on each write.
- R8: A fault-injection write with bit 2*PROT_BITS set and register index i in the bits just above it inverts the parity bit of register i. This happens only when `votedBits[CHAN_BITS-1:0]` are all 0, and `seqErr` then reads 1 from the next cycle.
- R9: The parity injection command has no effect while any channel enable bit is 1.
- R10: `seqErr` stays 1 across status reads while the parity mismatch remains. After the register is rewritten, it stays 1 until the next status read and is 0 after that read.
- R11: Writes to unmapped addresses change nothing, and reads of them return 0.
- R12: A status read returns `redErr` in bit 0 and `seqErr` in bit 1. Reading the injection register returns copy-A flips in [PROT_BITS-1:0] and copy-B flips in [2*PROT_BITS-1:PROT_BITS].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (side effects at the clock edge) |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data |
| votedBits | output | PROT_BITS | Majority-voted control bits |
| redErr | output | 1 | Redundancy disagreement flag |
| seqErr | output | 1 | Parity (sequencer) error flag |

## Verification
The copy registers and parity bits have no direct view at the ports, so a wrong internal state has to appear through the voted bits and the two flags. A lost or misrouted copy shows as a flipped `votedBits` bit, or as a flag that fails to rise, in the cycle after the injecting write. A latch that clears too early or too late shows on the first status read after the fault is removed. A corrupted parity bit raises `seqErr` one cycle after it is stored. Reading the registers back exposes any write that was lost or that landed in the wrong place.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  // fixed register map offsets
  localparam int ADDR_PROT     = 0;
  localparam int ADDR_FIR      = 1;
  localparam int ADDR_STAT     = 2;
  localparam int ADDR_REG_BASE = 4;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PROT,
    RD_FIR,
    RD_STAT,
    RD_REG
  } rdSel_e;

  // strobes from the decoder to the storage/datapath
  typedef struct packed {
    logic   wrProt;
    logic   wrFir;
    logic   wrReg;
    logic   rdStat;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        stb,
  output logic [IDX_W-1:0]  regIdx
);

  logic [ADDR_W-1:0] regOff;
  logic              isReg;

  always_comb begin
    regOff = addr - ADDR_W'(ADDR_REG_BASE);
    isReg  = (addr >= ADDR_W'(ADDR_REG_BASE)) && (regOff < ADDR_W'(NUM_REGS));
    regIdx = isReg ? regOff[IDX_W-1:0] : '0;

    stb        = '0;
    stb.rdSel  = RD_NONE;
    stb.wrProt = wrEn && (addr == ADDR_W'(ADDR_PROT));
    stb.wrFir  = wrEn && (addr == ADDR_W'(ADDR_FIR));
    stb.wrReg  = wrEn && isReg;
    stb.rdStat = rdEn && (addr == ADDR_W'(ADDR_STAT));

    if (rdEn) begin
      if (addr == ADDR_W'(ADDR_PROT))      stb.rdSel = RD_PROT;
      else if (addr == ADDR_W'(ADDR_FIR))  stb.rdSel = RD_FIR;
      else if (addr == ADDR_W'(ADDR_STAT)) stb.rdSel = RD_STAT;
      else if (isReg)                      stb.rdSel = RD_REG;
    end
  end

endmodule

// File: rtl/cfg_guard_datapath.sv
module cfg_guard_datapath
  import cfg_guard_pkg::*;
#(
  parameter int PROT_BITS = 4,
  parameter int CHAN_BITS = 2,
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           stb,
  input  logic [IDX_W-1:0]     regIdx,
  input  logic [DATA_W-1:0]    wrData,
  output logic [PROT_BITS-1:0] votedBits,
  output logic                 redErr,
  output logic                 seqErr,
  output logic [DATA_W-1:0]    rdData
);

  localparam int PAR_CMD_BIT = 2 * PROT_BITS;
  localparam int PAR_IDX_LSB = PAR_CMD_BIT + 1;

  // three stored copies plus injection masks on copies A and B
  logic [PROT_BITS-1:0] copyA, copyB, copyC;
  logic [PROT_BITS-1:0] flipA, flipB;
  logic [PROT_BITS-1:0] bitMismatch;
  logic                 redLive, redLatch;

  logic [DATA_W-1:0]    cfgRegs [NUM_REGS];
  logic [NUM_REGS-1:0]  parBits;
  logic [NUM_REGS-1:0]  parFail;
  logic                 parLive, seqLatch;

  logic                 chanOff;
  logic                 parInjHit;
  logic [IDX_W-1:0]     injIdx;

  // copies and injection masks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      copyA <= '0;
      copyB <= '0;
      copyC <= '0;
      flipA <= '0;
      flipB <= '0;
    end else if (stb.wrProt) begin
      copyA <= wrData[PROT_BITS-1:0];
      copyB <= wrData[PROT_BITS-1:0];
      copyC <= wrData[PROT_BITS-1:0];
      flipA <= '0;
      flipB <= '0;
    end else if (stb.wrFir) begin
      flipA <= wrData[PROT_BITS-1:0];
      flipB <= wrData[2*PROT_BITS-1:PROT_BITS];
    end
  end

  // per-bit majority voter
  for (genvar b = 0; b < PROT_BITS; b++) begin : g_vote
    logic a, bb, c;
    assign a  = copyA[b] ^ flipA[b];
    assign bb = copyB[b] ^ flipB[b];
    assign c  = copyC[b];
    assign votedBits[b]   = (a & bb) | (a & c) | (bb & c);
    assign bitMismatch[b] = (a != bb) || (bb != c);
  end

  assign redLive = |bitMismatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            redLatch <= 1'b0;
    else if (stb.wrProt)  redLatch <= 1'b0;
    else                  redLatch <= (redLatch & ~stb.rdStat) | redLive;
  end

  assign redErr = redLatch | redLive;

  // parity injection gated on all channel enables being off
  assign chanOff   = ~|votedBits[CHAN_BITS-1:0];
  assign injIdx    = wrData[PAR_IDX_LSB +: IDX_W];
  assign parInjHit = stb.wrFir && wrData[PAR_CMD_BIT] && chanOff &&
                     (int'(injIdx) < NUM_REGS);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgRegs[r] <= '0;
        parBits[r] <= 1'b0;
      end else if (stb.wrReg && (regIdx == IDX_W'(r))) begin
        cfgRegs[r] <= wrData;
        parBits[r] <= ^wrData;
      end else if (parInjHit && (injIdx == IDX_W'(r))) begin
        parBits[r] <= ~parBits[r];
      end
    end
    assign parFail[r] = (^cfgRegs[r]) ^ parBits[r];
  end

  assign parLive = |parFail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqLatch <= 1'b0;
    else       seqLatch <= (seqLatch & ~stb.rdStat) | parLive;
  end

  assign seqErr = seqLatch | parLive;

  // read mux
  always_comb begin
    rdData = '0;
    unique case (stb.rdSel)
      RD_PROT: rdData[PROT_BITS-1:0]   = votedBits;
      RD_FIR:  rdData[2*PROT_BITS-1:0] = {flipB, flipA};
      RD_STAT: rdData[1:0]             = {seqErr, redErr};
      RD_REG:  rdData                  = cfgRegs[regIdx];
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/safety_cfg_guard.sv
module safety_cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int PROT_BITS = 4,
  parameter int CHAN_BITS = 2,
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 16,   // must hold 2*PROT_BITS+1+index bits
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [PROT_BITS-1:0] votedBits,
  output logic                 redErr,
  output logic                 seqErr
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  ctlStrobe_t       stb;
  logic [IDX_W-1:0] regIdx;

  cfg_guard_ctrl #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb), .regIdx(regIdx)
  );

  cfg_guard_datapath #(
    .PROT_BITS(PROT_BITS), .CHAN_BITS(CHAN_BITS), .NUM_REGS(NUM_REGS),
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regIdx(regIdx), .wrData(wrData),
    .votedBits(votedBits), .redErr(redErr), .seqErr(seqErr), .rdData(rdData)
  );

endmodule

// File: rtl/safety_cfg_guard_chk.sv
module safety_cfg_guard_chk #(
  parameter int PROT_BITS = 4,
  parameter int CHAN_BITS = 2,
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    rdData,
  input logic [PROT_BITS-1:0] votedBits,
  input logic                 redErr,
  input logic                 seqErr
);

  logic protWr, firWr, statRd, unmapped;
  assign protWr   = wrEn && (addr == ADDR_W'(0));
  assign firWr    = wrEn && (addr == ADDR_W'(1));
  assign statRd   = rdEn && (addr == ADDR_W'(2));
  assign unmapped = (addr == ADDR_W'(3)) || (int'(addr) >= 4 + NUM_REGS);

  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (votedBits == '0 && !redErr && !seqErr));

  assert_prot_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    protWr |=> votedBits == $past(wrData[PROT_BITS-1:0]));

  assert_red_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    redErr && !statRd && !protWr |=> redErr);

  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    protWr |=> !redErr);

  assert_par_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    firWr && !seqErr && (votedBits[CHAN_BITS-1:0] != '0) |=> !seqErr);

  assert_seq_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    seqErr && !statRd |=> seqErr);

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && unmapped |-> rdData == '0);

endmodule

bind safety_cfg_guard safety_cfg_guard_chk #(
  .PROT_BITS(PROT_BITS), .CHAN_BITS(CHAN_BITS), .NUM_REGS(NUM_REGS),
  .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .votedBits(votedBits),
  .redErr(redErr), .seqErr(seqErr)
);

// File: tb/safety_cfg_guard_test.sv
`timescale 1ns/1ps
module safety_cfg_guard_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [3:0]  votedBits;
  logic        redErr, seqErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  safety_cfg_guard uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .votedBits(votedBits),
    .redErr(redErr), .seqErr(seqErr)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [3:0]  a;
    logic [15:0] d;
    logic        chkRd;
    logic [15:0] expRd;
    logic [3:0]  expVoted;
    logic        expRed;
    logic        expSeq;
    logic [7:0]  req;
  } vec_t;

  // wr rd addr data chkRd expRd voted red seq req
  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b0,4'd0,16'h000C,1'b0,16'h0000,4'hC,1'b0,1'b0,8'd2},  // R2 load
    '{1'b0,1'b1,4'd0,16'h0000,1'b1,16'h000C,4'hC,1'b0,1'b0,8'd2},  // R2 readback
    '{1'b1,1'b0,4'd4,16'h00A5,1'b0,16'h0000,4'hC,1'b0,1'b0,8'd7},  // R7 write
    '{1'b0,1'b1,4'd4,16'h0000,1'b1,16'h00A5,4'hC,1'b0,1'b0,8'd7},  // R7 read
    '{1'b1,1'b0,4'd1,16'h0001,1'b0,16'h0000,4'hC,1'b1,1'b0,8'd3},  // R3 single flip masked
    '{1'b0,1'b1,4'd1,16'h0000,1'b1,16'h0001,4'hC,1'b1,1'b0,8'd12}, // R12 fir readback
    '{1'b1,1'b0,4'd1,16'h0000,1'b0,16'h0000,4'hC,1'b1,1'b0,8'd5},  // R5 fault removed, flag held
    '{1'b0,1'b1,4'd2,16'h0000,1'b1,16'h0001,4'hC,1'b0,1'b0,8'd5},  // R5 read clears
    '{1'b0,1'b1,4'd2,16'h0000,1'b1,16'h0000,4'hC,1'b0,1'b0,8'd12}, // R12 status clear
    '{1'b1,1'b0,4'd1,16'h0044,1'b0,16'h0000,4'h8,1'b1,1'b0,8'd4},  // R4 double flip
    '{1'b1,1'b0,4'd0,16'h0003,1'b0,16'h0000,4'h3,1'b0,1'b0,8'd6},  // R6 rewrite clears
    '{1'b0,1'b1,4'd1,16'h0000,1'b1,16'h0000,4'h3,1'b0,1'b0,8'd6},  // R6 masks zero
    '{1'b1,1'b0,4'd1,16'h0100,1'b0,16'h0000,4'h3,1'b0,1'b0,8'd9},  // R9 gated
    '{1'b1,1'b0,4'd0,16'h0000,1'b0,16'h0000,4'h0,1'b0,1'b0,8'd2},  // R2 channels off
    '{1'b1,1'b0,4'd1,16'h0300,1'b0,16'h0000,4'h0,1'b0,1'b1,8'd8},  // R8 parity inject reg1
    '{1'b0,1'b1,4'd2,16'h0000,1'b1,16'h0002,4'h0,1'b0,1'b1,8'd10}, // R10 held while live
    '{1'b1,1'b0,4'd5,16'h0007,1'b0,16'h0000,4'h0,1'b0,1'b1,8'd10}, // R10 rewrite
    '{1'b0,1'b1,4'd2,16'h0000,1'b1,16'h0002,4'h0,1'b0,1'b0,8'd10}, // R10 read clears
    '{1'b0,1'b1,4'd2,16'h0000,1'b1,16'h0000,4'h0,1'b0,1'b0,8'd12}, // R12
    '{1'b1,1'b0,4'd3,16'hFFFF,1'b0,16'h0000,4'h0,1'b0,1'b0,8'd11}, // R11 unmapped write
    '{1'b0,1'b1,4'd3,16'h0000,1'b1,16'h0000,4'h0,1'b0,1'b0,8'd11}, // R11 unmapped read
    '{1'b0,1'b1,4'd4,16'h0000,1'b1,16'h00A5,4'h0,1'b0,1'b0,8'd11}  // R11 reg4 untouched
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic w, input logic r, input logic [3:0] a,
                      input logic [15:0] d, input logic chkRd,
                      input logic [15:0] expRd, input string req);
    @(negedge clk);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    #1;
    if (chkRd) check({req, " rdData"}, 32'(rdData), 32'(expRd));
    @(posedge clk);
    #2;
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic checkOut(input string req, input logic [3:0] v,
                          input logic r, input logic s);
    check({req, " votedBits"}, 32'(votedBits), 32'(v));
    check({req, " redErr"}, 32'(redErr), 32'(r));
    check({req, " seqErr"}, 32'(seqErr), 32'(s));
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    checkOut("R1 in reset", 4'h0, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    checkOut("R1 after reset", 4'h0, 1'b0, 1'b0);
    doOp(1'b0, 1'b1, 4'd2, 16'h0, 1'b1, 16'h0000, "R1 status");

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      doOp(VECS[i].wr, VECS[i].rd, VECS[i].a, VECS[i].d,
           VECS[i].chkRd, VECS[i].expRd, tag);
      checkOut(tag, VECS[i].expVoted, VECS[i].expRed, VECS[i].expSeq);
    end

    // R5: status read during a live disagreement keeps the flag
    doOp(1'b1, 1'b0, 4'd1, 16'h0008, 1'b0, 16'h0, "R5 inject");
    doOp(1'b0, 1'b1, 4'd2, 16'h0, 1'b1, 16'h0001, "R5 live read");
    checkOut("R5 live kept", 4'h0, 1'b1, 1'b0);
    doOp(1'b1, 1'b0, 4'd1, 16'h0000, 1'b0, 16'h0, "R5 remove");
    checkOut("R5 held", 4'h0, 1'b1, 1'b0);
    doOp(1'b0, 1'b1, 4'd2, 16'h0, 1'b1, 16'h0001, "R5 final read");
    checkOut("R5 cleared", 4'h0, 1'b0, 1'b0);

    // R4: dual flip on a clear bit sets the voted bit to the wrong value
    doOp(1'b1, 1'b0, 4'd1, 16'h0022, 1'b0, 16'h0, "R4 dual");
    checkOut("R4 dual bit1", 4'h2, 1'b1, 1'b0);
    doOp(1'b1, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0, "R6 rewrite");
    checkOut("R6 cleared", 4'h0, 1'b0, 1'b0);

    // R1: reset in mid-run with state present
    doOp(1'b1, 1'b0, 4'd0, 16'h000F, 1'b0, 16'h0, "R1 setup");
    doOp(1'b1, 1'b0, 4'd1, 16'h0001, 1'b0, 16'h0, "R1 setup fault");
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkOut("R1 async reset", 4'h0, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    doOp(1'b0, 1'b1, 4'd4, 16'h0, 1'b1, 16'h0000, "R1 reg cleared");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule